// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block guards a processor against runaway code. A counter advances on each pulse of a slow oscillator enable. Software must restart it before it reaches its terminal count, and only while a restart window is open. The restart is a write of the key value 0xAC to a single restart port. Any misuse of that port produces an immediate one-cycle reset request: a different value, a write made too early, or a write done as a single-bit manipulation. Letting the count run out does the same. The block also reports which of the four causes fired.

All settings come from an 8-bit configuration byte. The byte is captured while reset is asserted and cannot be changed until the next reset. It selects enable, window size, terminal count, an early-warning interrupt at three quarters of the terminal count, and whether counting continues while the system is in standby.

Top module: `wdtWindowWatchdog`

## Requirements
- R1: `optByte` is captured on every clock edge while `rstN` is low and is held after reset. Changes to `optByte` after reset have no effect. Bit 7 is the interrupt enable, bits 6:5 the window select, bit 4 the enable, bits 3:1 the terminal select and bit 0 the standby-run bit.
- R2: A write with `wrData` = 0xAC and `wrBitOp` = 0 while the window is open returns the counter to 0 and raises no reset request.
- R3: If the counter holds the terminal count minus one on a cycle with an active slow tick and no accepted restart, a reset request follows, with cause bit 0 set.
- R4: A write without `wrBitOp` whose data is not 0xAC raises a reset request on the next cycle, with cause bit 1 set.
- R5: A 0xAC write made while the window is closed raises a reset request on the next cycle, with cause bit 2 set.
- R6: A write with `wrBitOp` = 1 raises a reset request on the next cycle with cause bit 3 set, whatever its data.
- R7: The window select decodes as follows. 00: open when the count is at least half the terminal count. 01: open when the count is at least one quarter of it. 1x: always open.
- R8: With bit 7 set, `intervalIrq` pulses for one cycle in the cycle after the counter reaches three quarters of the terminal count. With bit 7 clear it never pulses.
- R9: With bit 0 clear and `standby` high, slow ticks are ignored and the count holds. With bit 0 set, counting continues in standby.
- R10: With bit 4 clear, the counter never runs. Writes, ticks and standby then raise neither a reset request nor an interrupt.
- R11: `rstReq` is a one-cycle pulse. On each pulse `rstCause` is one-hot and keeps that value until the next request or reset. The priority is bit-manipulation access, then wrong key, then closed window, then overflow. After a request the counter restarts from 0.
- R12: Terminal select code c gives a terminal count of 2^(10+c) slow ticks, capped at 2^17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; configuration captured while low |
| optByte | input | 8 | Configuration byte |
| slowTick | input | 1 | One-cycle enable from the slow oscillator |
| standby | input | 1 | System is in halt or stop mode |
| wrValid | input | 1 | Write strobe to the restart port |
| wrData | input | 8 | Write data to the restart port |
| wrBitOp | input | 1 | Current write comes from a single-bit manipulation |
| rstReq | output | 1 | One-cycle reset request |
| rstCause | output | 4 | One-hot cause of the last request: 0 overflow, 1 wrong key, 2 closed window, 3 bit access |
| intervalIrq | output | 1 | One-cycle early-warning interrupt |

## Verification
Some behaviours are checked on every cycle by assertions. Each bad-key, bit-access and closed-window write must give the matching cause one cycle later. An accepted restart must raise no request, the count must hold during standby, and a disabled block must stay silent. The exact overflow and interrupt cycles for different terminal selects can only be shown by the bench scenarios. So can the boundary counts where the 50% and 75% windows open, and the fact that the configuration byte is ignored after reset. A behavioural model compares all outputs on every cycle of those scenarios.

// File: rtl/wdtPkg.sv
package wdtPkg;

  localparam int NUM_CAUSE   = 4;
  localparam int CAUSE_OVF   = 0;
  localparam int CAUSE_KEY   = 1;
  localparam int CAUSE_EARLY = 2;
  localparam int CAUSE_BITOP = 3;

  // Field order matches the bit order of the configuration byte.
  typedef struct packed {
    logic       irqEn;
    logic [1:0] winSel;
    logic       enable;
    logic [2:0] ovfSel;
    logic       stbyRun;
  } wdtCfgT;

  typedef struct packed {
    logic advance;
    logic clear;
  } wdtStrobeT;

endpackage

// File: rtl/wdtCounter.sv
module wdtCounter
  import wdtPkg::*;
#(
  parameter int CNT_W    = 17,
  parameter int BASE_LOG = 10,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobeT        strobe,
  input  logic [SEL_W-1:0] ovfSel,
  input  logic [1:0]       winSel,
  output logic [CNT_W-1:0] count,
  output logic             termHit,
  output logic             windowOpen,
  output logic             irqPoint
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] lastTab  [NSEL];
  logic [CNT_W-1:0] halfTab  [NSEL];
  logic [CNT_W-1:0] quartTab [NSEL];
  logic [CNT_W-1:0] irqTab   [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_limits
    localparam int LG = ((BASE_LOG + g) > CNT_W) ? CNT_W : (BASE_LOG + g);
    localparam logic [CNT_W:0] LIM   = {{CNT_W{1'b0}}, 1'b1} << LG;
    localparam logic [CNT_W:0] LAST  = LIM - 1;
    localparam logic [CNT_W:0] HALF  = LIM >> 1;
    localparam logic [CNT_W:0] QUART = LIM >> 2;
    localparam logic [CNT_W:0] IRQV  = LIM - QUART - 1;
    assign lastTab[g]  = LAST[CNT_W-1:0];
    assign halfTab[g]  = HALF[CNT_W-1:0];
    assign quartTab[g] = QUART[CNT_W-1:0];
    assign irqTab[g]   = IRQV[CNT_W-1:0];
  end

  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN)               countQ <= '0;
    else if (strobe.clear)   countQ <= '0;
    else if (strobe.advance) countQ <= countQ + 1'b1;
  end

  always_comb begin
    termHit  = (countQ == lastTab[ovfSel]);
    irqPoint = (countQ == irqTab[ovfSel]);
    unique case (winSel)
      2'b00:   windowOpen = (countQ >= halfTab[ovfSel]);
      2'b01:   windowOpen = (countQ >= quartTab[ovfSel]);
      default: windowOpen = 1'b1;
    endcase
  end

  assign count = countQ;

endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdtPkg::*;
#(
  parameter logic [7:0] KEY = 8'hAC
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           optByte,
  input  logic                 slowTick,
  input  logic                 standby,
  input  logic                 wrValid,
  input  logic [7:0]           wrData,
  input  logic                 wrBitOp,
  input  logic                 termHit,
  input  logic                 windowOpen,
  input  logic                 irqPoint,
  output wdtCfgT               cfg,
  output wdtStrobeT            strobe,
  output logic                 rstReq,
  output logic [NUM_CAUSE-1:0] rstCause,
  output logic                 intervalIrq
);
  wdtCfgT               cfgQ;
  logic                 reqQ, irqQ;
  logic [NUM_CAUSE-1:0] causeQ, causeNext;
  logic                 adv, goodWr, irqNext;

  always_comb begin
    adv       = cfgQ.enable && slowTick && (cfgQ.stbyRun || !standby);
    causeNext = '0;
    goodWr    = 1'b0;
    if (cfgQ.enable && wrValid) begin
      if (wrBitOp)           causeNext[CAUSE_BITOP] = 1'b1;
      else if (wrData != KEY) causeNext[CAUSE_KEY]  = 1'b1;
      else if (!windowOpen)  causeNext[CAUSE_EARLY] = 1'b1;
      else                   goodWr = 1'b1;
    end
    if ((causeNext == '0) && !goodWr && adv && termHit)
      causeNext[CAUSE_OVF] = 1'b1;
    strobe.advance = adv;
    strobe.clear   = goodWr || (causeNext != '0);
    irqNext        = cfgQ.irqEn && adv && !strobe.clear && irqPoint;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= wdtCfgT'(optByte);
      reqQ   <= 1'b0;
      causeQ <= '0;
      irqQ   <= 1'b0;
    end else begin
      reqQ <= (causeNext != '0);
      if (causeNext != '0) causeQ <= causeNext;
      irqQ <= irqNext;
    end
  end

  assign cfg         = cfgQ;
  assign rstReq      = reqQ;
  assign rstCause    = causeQ;
  assign intervalIrq = irqQ;

endmodule

// File: rtl/wdtWindowWatchdog.sv
module wdtWindowWatchdog
  import wdtPkg::*;
#(
  parameter int         CNT_W    = 17,
  parameter int         BASE_LOG = 10,
  parameter logic [7:0] KEY      = 8'hAC
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] optByte,
  input  logic       slowTick,
  input  logic       standby,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrBitOp,
  output logic       rstReq,
  output logic [3:0] rstCause,
  output logic       intervalIrq
);
  wdtCfgT           cfgQ;
  wdtStrobeT        strobe;
  logic [CNT_W-1:0] count;
  logic             termHit, windowOpen, irqPoint;

  wdtControl #(.KEY(KEY)) ctrl_i (
    .clk(clk), .rstN(rstN), .optByte(optByte), .slowTick(slowTick),
    .standby(standby), .wrValid(wrValid), .wrData(wrData), .wrBitOp(wrBitOp),
    .termHit(termHit), .windowOpen(windowOpen), .irqPoint(irqPoint),
    .cfg(cfgQ), .strobe(strobe), .rstReq(rstReq), .rstCause(rstCause),
    .intervalIrq(intervalIrq)
  );

  wdtCounter #(.CNT_W(CNT_W), .BASE_LOG(BASE_LOG), .SEL_W(3)) cnt_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ovfSel(cfgQ.ovfSel),
    .winSel(cfgQ.winSel), .count(count), .termHit(termHit),
    .windowOpen(windowOpen), .irqPoint(irqPoint)
  );

endmodule

// File: rtl/wdtWindowWatchdog_chk.sv
module wdtWindowWatchdog_chk #(
  parameter int         CNT_W = 17,
  parameter logic [7:0] KEY   = 8'hAC
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgEnable,
  input logic             cfgStbyRun,
  input logic             standby,
  input logic             wrValid,
  input logic [7:0]       wrData,
  input logic             wrBitOp,
  input logic             windowOpen,
  input logic [CNT_W-1:0] count,
  input logic             rstReq,
  input logic [3:0]       rstCause,
  input logic             intervalIrq
);
  p_good_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && wrValid && !wrBitOp && wrData == KEY && windowOpen) |=> !rstReq);

  p_bad_key_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && wrValid && !wrBitOp && wrData != KEY) |=> (rstReq && rstCause == 4'b0010));

  p_early_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && wrValid && !wrBitOp && wrData == KEY && !windowOpen)
      |=> (rstReq && rstCause == 4'b0100));

  p_bit_access_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && wrValid && wrBitOp) |=> (rstReq && rstCause == 4'b1000));

  p_standby_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && !cfgStbyRun && standby && !wrValid) |=> $stable(count));

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (!rstReq && !intervalIrq));

  p_cause_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $onehot(rstCause));

endmodule

bind wdtWindowWatchdog wdtWindowWatchdog_chk #(.CNT_W(CNT_W), .KEY(KEY)) chk_i (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgQ.enable), .cfgStbyRun(cfgQ.stbyRun),
  .standby(standby), .wrValid(wrValid), .wrData(wrData), .wrBitOp(wrBitOp),
  .windowOpen(windowOpen), .count(count), .rstReq(rstReq),
  .rstCause(rstCause), .intervalIrq(intervalIrq)
);

// File: tb/wdtWindowWatchdog_tb_top.sv
module wdtWindowWatchdog_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] optByte = 8'h50;
  logic       slowTick = 1'b1;
  logic       standby = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       wrBitOp = 1'b0;
  logic       rstReq;
  logic [3:0] rstCause;
  logic       intervalIrq;

  int checks = 0;
  int failures = 0;
  int reqSeen = 0;
  int irqSeen = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wdtWindowWatchdog dut_i (
    .clk(clk), .rstN(rstN), .optByte(optByte), .slowTick(slowTick),
    .standby(standby), .wrValid(wrValid), .wrData(wrData), .wrBitOp(wrBitOp),
    .rstReq(rstReq), .rstCause(rstCause), .intervalIrq(intervalIrq)
  );

  // Behavioural reference model
  int         mCnt = 0;
  bit         mEn, mIrqEn, mStby;
  int         mWin, mSel;
  logic       expReq = 1'b0, expIrq = 1'b0;
  logic [3:0] expCause = 4'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mIrqEn = optByte[7]; mWin = int'(optByte[6:5]); mEn = optByte[4];
      mSel = int'(optByte[3:1]); mStby = optByte[0];
      mCnt = 0; expReq = 1'b0; expIrq = 1'b0; expCause = 4'b0;
    end else begin
      int  term;
      bit  open, adv, good;
      logic [3:0] c;
      term = 1 << ((10 + mSel) > 17 ? 17 : (10 + mSel));
      open = (mWin == 0) ? (mCnt >= term / 2) :
             (mWin == 1) ? (mCnt >= term / 4) : 1'b1;
      adv  = mEn && slowTick && (mStby || !standby);
      c = 4'b0; good = 0;
      expReq = 1'b0; expIrq = 1'b0;
      if (mEn && wrValid) begin
        if (wrBitOp) c = 4'b1000;
        else if (wrData != 8'hAC) c = 4'b0010;
        else if (!open) c = 4'b0100;
        else good = 1;
      end
      if (c == 0 && !good && adv && mCnt == term - 1) c = 4'b0001;
      if (c != 0) begin expReq = 1'b1; expCause = c; mCnt = 0; end
      else if (good) mCnt = 0;
      else if (adv) begin
        mCnt++;
        if (mIrqEn && mCnt == term - term / 4) expIrq = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (rstReq !== expReq || rstCause !== expCause || intervalIrq !== expIrq) begin
        failures++;
        $display("FAIL R11/R8 model compare actual req=%b cause=%b irq=%b expected req=%b cause=%b irq=%b",
                 rstReq, rstCause, intervalIrq, expReq, expCause, expIrq);
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rstN && rstReq) reqSeen++;
    if (rstN && intervalIrq) irqSeen++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [7:0] opt);
    @(negedge clk);
    rstN = 1'b0; optByte = opt; wrValid = 1'b0; wrBitOp = 1'b0; standby = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    reqSeen = 0; irqSeen = 0;
  endtask

  task automatic doWrite(input logic [7:0] d, input logic bitOp);
    wrValid = 1'b1; wrData = d; wrBitOp = bitOp;
    @(negedge clk);
    wrValid = 1'b0; wrBitOp = 1'b0;
  endtask

  task automatic waitReq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rstReq && n < 20000);
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!intervalIrq && n < 20000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    // reset state (R11)
    doReset(8'h50);
    check(rstReq == 0 && rstCause == 0 && intervalIrq == 0, "R11 reset state", int'(rstCause), 0);

    // R4 wrong key
    doWrite(8'h55, 1'b0);
    check(rstReq == 1 && rstCause == 4'b0010, "R4 wrong key cause", int'(rstCause), 2);
    @(negedge clk);
    check(rstReq == 0 && rstCause == 4'b0010, "R11 pulse one cycle, cause held", int'(rstReq), 0);

    // R6 bit access with correct key
    doReset(8'h50);
    doWrite(8'hAC, 1'b1);
    check(rstReq == 1 && rstCause == 4'b1000, "R6 bit access cause", int'(rstCause), 8);

    // R2 restart in open window prevents overflow
    doReset(8'h50);
    repeat (1000) @(negedge clk);
    doWrite(8'hAC, 1'b0);
    repeat (1000) @(negedge clk);
    check(reqSeen == 0, "R2 restart accepted, no request", reqSeen, 0);

    // R3 and R12 overflow timing
    doReset(8'h50);
    waitReq(n);
    check(n == 1024, "R3 overflow cycle sel0", n, 1024);
    check(rstCause == 4'b0001, "R3 overflow cause", int'(rstCause), 1);
    doReset(8'h52);
    waitReq(n);
    check(n == 2048, "R12 overflow cycle sel1", n, 2048);
    doReset(8'h54);
    waitReq(n);
    check(n == 4096, "R12 overflow cycle sel2", n, 4096);

    // R5 and R7 window boundaries, 50%
    doReset(8'h10);
    repeat (511) @(negedge clk);
    doWrite(8'hAC, 1'b0);
    check(rstReq == 1 && rstCause == 4'b0100, "R5 closed at 511 of 50% window", int'(rstCause), 4);
    doReset(8'h10);
    repeat (512) @(negedge clk);
    doWrite(8'hAC, 1'b0);
    check(rstReq == 0, "R7 open at 512 of 50% window", int'(rstReq), 0);
    // 75%
    doReset(8'h30);
    repeat (255) @(negedge clk);
    doWrite(8'hAC, 1'b0);
    check(rstReq == 1 && rstCause == 4'b0100, "R7 closed at 255 of 75% window", int'(rstCause), 4);
    doReset(8'h30);
    repeat (256) @(negedge clk);
    doWrite(8'hAC, 1'b0);
    check(rstReq == 0, "R7 open at 256 of 75% window", int'(rstReq), 0);

    // R8 interval interrupt
    doReset(8'hD0);
    waitIrq(n);
    check(n == 768, "R8 interrupt cycle", n, 768);
    @(negedge clk);
    check(intervalIrq == 0, "R8 interrupt one cycle", int'(intervalIrq), 0);
    doReset(8'h50);
    waitReq(n);
    check(irqSeen == 0, "R8 no interrupt when disabled in config", irqSeen, 0);

    // R9 standby
    doReset(8'h50);
    standby = 1'b1;
    repeat (2000) @(negedge clk);
    check(reqSeen == 0, "R9 count holds in standby", reqSeen, 0);
    standby = 1'b0;
    waitReq(n);
    check(n == 1024, "R9 count resumes from held value", n, 1024);
    doReset(8'h51);
    standby = 1'b1;
    waitReq(n);
    standby = 1'b0;
    check(n == 1024, "R9 standby-run keeps counting", n, 1024);

    // R10 disabled
    doReset(8'h40);
    doWrite(8'h00, 1'b1);
    doWrite(8'h12, 1'b0);
    repeat (2000) @(negedge clk);
    check(reqSeen == 0 && irqSeen == 0, "R10 disabled stays silent", reqSeen, 0);

    // R1 configuration ignored after reset
    doReset(8'h50);
    optByte = 8'h10;
    repeat (10) @(negedge clk);
    doWrite(8'hAC, 1'b0);
    check(rstReq == 0, "R1 window not changed after reset", int'(rstReq), 0);

    // R11 priority: bit access wins over wrong key
    doReset(8'h10);
    doWrite(8'h33, 1'b1);
    check(rstCause == 4'b1000, "R11 priority bit access over key", int'(rstCause), 8);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule